// File: doc/BRIEF.md
# Four-Channel External Interrupt Front End with Noise Filter

This block turns four asynchronous interrupt pins into four sticky interrupt request flags. Each pin first goes through a two-stage synchronizer. An optional digital filter can then follow it. The filter takes samples of the synchronized level at a rate chosen per channel. It changes its stored level only when three samples in a row agree on the new value. An edge detector watches the resulting level and sets the channel's request flag. It can react to one chosen edge, or to both edges.

Software configures each channel with four controls: an enable bit, a two-bit filter code, a both-edges bit and a polarity bit. The flags stay set until software clears them with a one-cycle strobe. All channels share one free-running prescaler, which produces the slower sample enables. Priority, vectoring and pin multiplexing are handled elsewhere.

Top module: `ext_irq_front`

## Requirements
- R1: The four channels are independent. Activity on one pin, or a change to its controls, never changes another channel's request flag.
- R2: Filter code 00 bypasses the filter. A pin change is seen after the two synchronizer flops, and the request flag rises on the third rising clock edge after the pin changes.
- R3: Filter code 01 samples on every clock. The filtered level changes only after three consecutive samples agree, so a pulse two clocks wide is ignored and a pulse three clocks wide is accepted.
- R4: Filter code 10 samples once every 8 clocks. A pulse of 12 clocks is ignored, and a pulse of 30 clocks is accepted.
- R5: Filter code 11 samples once every 32 clocks. A pulse of 60 clocks is ignored, and a pulse of 100 clocks is accepted. The shared slow sample enable is never active on two consecutive clocks, and it coincides with the medium sample enable.
- R6: A request flag stays 1 until a clear strobe arrives. A clear strobe with no coinciding edge returns the flag to 0 on the next clock.
- R7: With the both-edges bit at 1, both an accepted rising change and an accepted falling change set the flag.
- R8: With the both-edges bit at 0, the polarity bit selects the edge: 1 means rising and 0 means falling. The other edge leaves the flag unchanged.
- R9: With the enable bit at 0, the channel never sets its request flag.
- R10: When a clear strobe and an accepted edge fall in the same cycle, the flag ends up set.
- R11: Reset is synchronous and active high. It drives every flag to 0 and loads every filter and edge detector with the current synchronized pin level. As a result, a pin that is held high through reset raises no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | NUM_CH | Raw asynchronous interrupt pins |
| chan_en_i | input | NUM_CH | Per-channel enable |
| filt_sel_i | input | 2*NUM_CH | Per-channel filter code; bits [2c+1:2c] belong to channel c |
| both_edge_i | input | NUM_CH | Per-channel both-edges select |
| rise_sel_i | input | NUM_CH | Per-channel polarity in single-edge mode (1 = rising) |
| clr_i | input | NUM_CH | Per-channel one-cycle flag clear strobe |
| req_o | output | NUM_CH | Registered per-channel interrupt request flags |

## Verification
The bench builds the block with its default parameters: four channels, a medium divider of 8 and a slow divider of 32. With these values a full slow-rate acceptance, meaning three samples spaced 32 clocks apart, completes in about a hundred clocks. That lets directed pulses sit just inside and just outside each sampling rate's acceptance window. Random segments of a few hundred clocks per configuration then cover every filter code against every edge mode, including code changes while a pin is moving and clear strobes that coincide with edges.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  // filter select encoding, one field per channel
  typedef enum logic [1:0] {
    FSEL_BYPASS = 2'b00,
    FSEL_DIV1   = 2'b01,
    FSEL_MID    = 2'b10,
    FSEL_SLOW   = 2'b11
  } fsel_e;

  localparam int unsigned MATCH_LEN  = 3;
  localparam int unsigned SYNC_DEPTH = 2;
endpackage

// File: rtl/ext_irq_prescale.sv
// Free-running counter shared by all channels; DIV_MID and DIV_SLOW are powers of two.
module ext_irq_prescale #(
  parameter int unsigned DIV_MID  = 8,
  parameter int unsigned DIV_SLOW = 32
) (
  input  logic clk,
  input  logic rst,
  output logic tick_mid_o,
  output logic tick_slow_o
);
  localparam int unsigned CNT_W = (DIV_SLOW > 1) ? $clog2(DIV_SLOW) : 1;
  localparam int unsigned MID_W = (DIV_MID > 1) ? $clog2(DIV_MID) : 1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else if (cnt_q == CNT_W'(DIV_SLOW - 1)) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  assign tick_mid_o  = (cnt_q[MID_W-1:0] == '0);
  assign tick_slow_o = (cnt_q == '0);
endmodule

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) chain_q <= d_i;
    end else begin : g_many
      always_ff @(posedge clk) chain_q <= {chain_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ext_irq_filter.sv
module ext_irq_filter
  import ext_irq_pkg::*;
#(
  parameter int unsigned MATCH = MATCH_LEN
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sync_i,
  input  logic [1:0] fsel_i,
  input  logic       tick_mid_i,
  input  logic       tick_slow_i,
  output logic       level_o
);
  logic [MATCH-1:0] hist_q;
  logic [MATCH-1:0] win;
  logic             lvl_q;
  logic             sample;
  logic             bypass;

  assign bypass = (fsel_e'(fsel_i) == FSEL_BYPASS);
  assign win    = {hist_q[MATCH-2:0], sync_i};

  always_comb begin
    case (fsel_e'(fsel_i))
      FSEL_DIV1: sample = 1'b1;
      FSEL_MID:  sample = tick_mid_i;
      FSEL_SLOW: sample = tick_slow_i;
      default:   sample = 1'b0;
    endcase
  end

  // in bypass the stored level tracks the pin so a later switch adds no edge
  always_ff @(posedge clk) begin
    if (rst || bypass) begin
      hist_q <= {MATCH{sync_i}};
      lvl_q  <= sync_i;
    end else if (sample) begin
      hist_q <= win;
      if (&win)       lvl_q <= 1'b1;
      else if (~|win) lvl_q <= 1'b0;
    end
  end

  assign level_o = bypass ? sync_i : lvl_q;
endmodule

// File: rtl/ext_irq_flag.sv
module ext_irq_flag (
  input  logic clk,
  input  logic rst,
  input  logic level_i,
  input  logic init_i,
  input  logic en_i,
  input  logic both_i,
  input  logic rise_i,
  input  logic clr_i,
  output logic req_o
);
  logic prev_q;
  logic rose, fell, hit;

  assign rose = level_i & ~prev_q;
  assign fell = ~level_i & prev_q;
  assign hit  = en_i & (both_i ? (rose | fell) : (rise_i ? rose : fell));

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= init_i;
      req_o  <= 1'b0;
    end else begin
      prev_q <= level_i;
      if (hit)        req_o <= 1'b1;   // set has priority over clear
      else if (clr_i) req_o <= 1'b0;
    end
  end
endmodule

// File: rtl/ext_irq_front.sv
module ext_irq_front
  import ext_irq_pkg::*;
#(
  parameter int unsigned NUM_CH   = 4,
  parameter int unsigned DIV_MID  = 8,
  parameter int unsigned DIV_SLOW = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_CH-1:0]     pin_i,
  input  logic [NUM_CH-1:0]     chan_en_i,
  input  logic [2*NUM_CH-1:0]   filt_sel_i,
  input  logic [NUM_CH-1:0]     both_edge_i,
  input  logic [NUM_CH-1:0]     rise_sel_i,
  input  logic [NUM_CH-1:0]     clr_i,
  output logic [NUM_CH-1:0]     req_o
);
  logic tick_mid;
  logic tick_slow;

  ext_irq_prescale #(.DIV_MID(DIV_MID), .DIV_SLOW(DIV_SLOW)) u_prescale (
    .clk(clk), .rst(rst), .tick_mid_o(tick_mid), .tick_slow_o(tick_slow)
  );

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic pin_sync;
      logic level;

      ext_irq_sync #(.STAGES(SYNC_DEPTH)) u_sync (
        .clk(clk), .d_i(pin_i[c]), .q_o(pin_sync)
      );

      ext_irq_filter #(.MATCH(MATCH_LEN)) u_filter (
        .clk(clk), .rst(rst), .sync_i(pin_sync), .fsel_i(filt_sel_i[2*c +: 2]),
        .tick_mid_i(tick_mid), .tick_slow_i(tick_slow), .level_o(level)
      );

      ext_irq_flag u_flag (
        .clk(clk), .rst(rst), .level_i(level), .init_i(pin_sync),
        .en_i(chan_en_i[c]), .both_i(both_edge_i[c]), .rise_i(rise_sel_i[c]),
        .clr_i(clr_i[c]), .req_o(req_o[c])
      );
    end
  endgenerate
endmodule

// File: rtl/ext_irq_front_chk.sv
module ext_irq_front_chk #(
  parameter int unsigned NUM_CH = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_CH-1:0] en_i,
  input logic [NUM_CH-1:0] clr_i,
  input logic [NUM_CH-1:0] req_i,
  input logic              tick_mid_i,
  input logic              tick_slow_i
);
  assert_reset_clears_R11: assert property (@(posedge clk) rst |=> (req_i == '0));

  assert_slow_spaced_R5: assert property (@(posedge clk) disable iff (rst)
    tick_slow_i |=> !tick_slow_i);

  assert_slow_on_mid_R5: assert property (@(posedge clk) disable iff (rst)
    tick_slow_i |-> tick_mid_i);

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
      assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (req_i[c] && !clr_i[c]) |=> req_i[c]);

      assert_disabled_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (!en_i[c] && !req_i[c]) |=> !req_i[c]);
    end
  endgenerate
endmodule

bind ext_irq_front ext_irq_front_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst(rst), .en_i(chan_en_i), .clr_i(clr_i), .req_i(req_o),
  .tick_mid_i(tick_mid), .tick_slow_i(tick_slow)
);

// File: tb/ext_irq_front_bench.sv
module ext_irq_front_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NCH-1:0]   pin = '0, en = '0, both = '0, rise = '0, clr = '0;
  logic [2*NCH-1:0] fsel = '0;
  logic [NCH-1:0]   req;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench reference state
  logic [NCH-1:0] m_s1 = '0, m_s2 = '0, m_lvl = '0, m_prev = '0, m_req = '0;
  logic [2:0]     m_hist [NCH];
  int             m_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ext_irq_front u_ext_irq_front (
    .clk(clk), .rst(rst), .pin_i(pin), .chan_en_i(en), .filt_sel_i(fsel),
    .both_edge_i(both), .rise_sel_i(rise), .clr_i(clr), .req_o(req)
  );

  function automatic string tag_of(input logic [1:0] code);
    case (code)
      2'b00:   return "R2";
      2'b01:   return "R3";
      2'b10:   return "R4";
      default: return "R5";
    endcase
  endfunction

  // advance the reference by one clock, all from the previous state
  function automatic void model_tick();
    logic [NCH-1:0] s2o = m_s2;
    logic [NCH-1:0] lvlo = m_lvl;
    logic [NCH-1:0] prevo = m_prev;
    bit tm = (m_cnt % 8) == 0;
    bit ts = (m_cnt == 0);
    for (int c = 0; c < NCH; c++) begin
      logic [1:0] code = fsel[2*c +: 2];
      logic eff = (code == 2'b00) ? s2o[c] : lvlo[c];
      bit up = eff && !prevo[c];
      bit dn = !eff && prevo[c];
      bit smp = (code == 2'b01) || (code == 2'b10 && tm) || (code == 2'b11 && ts);
      if (rst) begin
        m_req[c] = 1'b0; m_prev[c] = s2o[c]; m_lvl[c] = s2o[c];
        m_hist[c] = s2o[c] ? 3'b111 : 3'b000;
      end else begin
        bit hit = en[c] && (both[c] ? (up || dn) : (rise[c] ? up : dn));
        if (hit) m_req[c] = 1'b1;
        else if (clr[c]) m_req[c] = 1'b0;
        m_prev[c] = eff;
        if (code == 2'b00) begin
          m_lvl[c] = s2o[c]; m_hist[c] = s2o[c] ? 3'b111 : 3'b000;
        end else if (smp) begin
          m_hist[c] = {m_hist[c][1:0], s2o[c]};
          if (m_hist[c] == 3'b111) m_lvl[c] = 1'b1;
          else if (m_hist[c] == 3'b000) m_lvl[c] = 1'b0;
        end
      end
    end
    m_cnt = rst ? 0 : (m_cnt + 1) % 32;
    m_s2 = m_s1;
    m_s1 = pin;
  endfunction

  task automatic step();
    @(posedge clk);
    model_tick();
    @(negedge clk);
    if (!rst) begin
      for (int c = 0; c < NCH; c++) begin
        checks++;
        if (req[c] !== m_req[c]) begin
          errors++;
          $display("FAIL %s ch%0d req actual=%0b expected=%0b", tag_of(fsel[2*c +: 2]),
                   c, req[c], m_req[c]);
        end
      end
    end
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse(input int c, input int width);
    pin[c] = ~pin[c];
    steps(width);
    pin[c] = ~pin[c];
  endtask

  initial begin
    void'($urandom(32'd5150));
    for (int c = 0; c < NCH; c++) m_hist[c] = '0;
    // R11: pins high through reset, all channels armed for both edges
    pin = '1; en = '1; both = '1; fsel = 8'b01010101;
    steps(6);
    chk(req == '0, "R11 during reset", req, 0);
    rst = 1'b0;
    steps(12);
    chk(req == '0, "R11 no false edge", req, 0);

    // R2: bypass, falling edge on channel 0, three-edge latency
    both = '0; rise = '0; fsel = 8'b01010100;
    steps(2);
    pin[0] = 1'b0;
    steps(2);
    chk(req[0] == 1'b0, "R2 too early", req[0], 0);
    step();
    chk(req[0] == 1'b1, "R2 latency", req[0], 1);
    steps(5);
    chk(req[0] == 1'b1, "R6 sticky", req[0], 1);
    clr[0] = 1'b1; step(); clr[0] = 1'b0;
    chk(req[0] == 1'b0, "R6 clear", req[0], 0);
    pin[0] = 1'b1; steps(5);
    chk(req[0] == 1'b0, "R8 rising ignored in falling mode", req[0], 0);
    // R10: clear lands in the cycle the edge is accepted
    pin[0] = 1'b0; steps(2);
    clr[0] = 1'b1; step(); clr[0] = 1'b0;
    chk(req[0] == 1'b1, "R10 set beats clear", req[0], 1);
    clr[0] = 1'b1; step(); clr[0] = 1'b0;

    // R3: per-clock filter on channel 1, both edges
    both[1] = 1'b1; pin[1] = 1'b0; steps(10);
    clr[1] = 1'b1; step(); clr[1] = 1'b0;
    pulse(1, 2); steps(10);
    chk(req[1] == 1'b0, "R3 two-clock glitch", req[1], 0);
    pulse(1, 3); steps(10);
    chk(req[1] == 1'b1, "R3 three-clock pulse", req[1], 1);
    chk(req[3:2] == 2'b00, "R1 other channels untouched", req[3:2], 0);

    // R8: rising-only mode ignores the falling change
    clr[1] = 1'b1; step(); clr[1] = 1'b0;
    both[1] = 1'b0; rise[1] = 1'b1;
    pin[1] = 1'b1; steps(8);
    chk(req[1] == 1'b1, "R8 rising accepted", req[1], 1);
    clr[1] = 1'b1; step(); clr[1] = 1'b0;
    pin[1] = 1'b0; steps(8);
    chk(req[1] == 1'b0, "R8 falling ignored", req[1], 0);

    // R4 / R5: slower sample rates on channel 2, both edges
    both[2] = 1'b1; pin[2] = 1'b0; fsel[5:4] = 2'b10; steps(70);
    clr[2] = 1'b1; step(); clr[2] = 1'b0;
    pulse(2, 12); steps(40);
    chk(req[2] == 1'b0, "R4 short pulse", req[2], 0);
    pulse(2, 30); steps(40);
    chk(req[2] == 1'b1, "R4 long pulse", req[2], 1);
    clr[2] = 1'b1; step(); clr[2] = 1'b0;
    fsel[5:4] = 2'b11; steps(40);
    pulse(2, 60); steps(120);
    chk(req[2] == 1'b0, "R5 short pulse", req[2], 0);
    pulse(2, 100); steps(120);
    chk(req[2] == 1'b1, "R5 long pulse", req[2], 1);

    // R9: disabled channel 3 with a busy pin
    en[3] = 1'b0; fsel[7:6] = 2'b00; both[3] = 1'b1;
    for (int i = 0; i < 40; i++) begin pin[3] = ~pin[3]; steps(4); end
    chk(req[3] == 1'b0, "R9 disabled channel", req[3], 0);

    // R7 and mixed: random segments checked cycle by cycle against the reference
    for (int seg = 0; seg < 16; seg++) begin
      fsel = 8'($urandom); en = 4'($urandom) | 4'b0001;
      both = 4'($urandom); rise = 4'($urandom);
      for (int t = 0; t < 200; t++) begin
        for (int c = 0; c < NCH; c++) begin
          if ($urandom_range(0, 11) == 0) pin[c] = ~pin[c];
          clr[c] = ($urandom_range(0, 29) == 0);
        end
        step();
      end
      clr = '0;
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule